// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block is the operand store of a floating-point coprocessor. It holds eight 80-bit registers, each with a sign bit, a 15-bit exponent and a 64-bit significand. Software never names these registers by their physical slot. It names them by their distance from a wrapping top-of-stack pointer: ST(0) is the current top, and ST(7) is the deepest entry. The plain name ST means ST(0).

Next to each register sits a 2-bit tag. The tag records whether the register is empty or holds a zero, a special value or an ordinary value. Operations are push, pop, overwrite of ST(i), exchange of ST(0) with ST(i), and a read check of ST(i). The block uses the tags to detect two stack faults. A push onto a register that still holds data is an overflow. Popping or checking an empty register is an underflow.

The arithmetic unit reads ST(0) and ST(i) through two combinational ports. It then drives results back with the write or push operations. The top pointer and the fault result of the last operation leave the block as one status field. All eight tags leave the block as one tag word.

Top module: `fp_stack_file`

## Requirements
- R1: A synchronous active-high reset sets every tag to empty (2'b11), sets the top pointer to 0 and clears both fault flags.
- R2: ST(i) maps to physical register (TOP + i) mod 8. Physical register k owns bits [2k+1:2k] of the tag word. The status field carries TOP in bits [5:3], a stack-fault bit in bit 2 (set when either fault is set), underflow in bit 1 and overflow in bit 0.
- R3: A push first computes TOP-1 mod 8. If that register is empty, the push writes the input word there, tags it and makes it the new top. If that register is not empty, the push raises overflow and changes no data, no tag and no pointer.
- R4: Every value written is tagged from bits [78:64] (exponent) and bits [63:0] (significand); the sign in bit 79 is ignored. The tag is 2'b10 (special) when the exponent is all ones, 2'b01 (zero) when exponent and significand are both all zero, and 2'b00 (valid) in every other case.
- R5: A pop of a non-empty ST(0) marks that register empty and increments TOP mod 8. A pop of an empty ST(0) raises underflow and changes nothing.
- R6: A write to ST(i) replaces the data and tag of that register whatever its previous tag was. It leaves TOP unchanged and raises no fault.
- R7: An exchange swaps both data and tags of ST(0) and ST(i) in a single cycle, empty tags included. It leaves TOP unchanged and raises no fault.
- R8: A check of ST(i) raises underflow when ST(i) is empty and changes no state.
- R9: The two fault flags describe only the operation of the previous cycle. Any following operation that does not fault clears them.
- R10: Operation codes are 0 idle, 1 push, 2 pop, 3 write ST(i), 4 exchange, 5 check. Codes 6 and 7 behave as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (R10) |
| idx_i | input | 3 | Stack-relative index i for ST(i) |
| wr_data_i | input | 80 | Word to push or write |
| st0_data_o | output | 80 | Data of ST(0) |
| st0_tag_o | output | 2 | Tag of ST(0) |
| sti_data_o | output | 80 | Data of ST(idx_i) |
| sti_tag_o | output | 2 | Tag of ST(idx_i) |
| tag_word_o | output | 16 | All tags, indexed by physical register |
| status_o | output | 6 | {TOP, stack fault, underflow, overflow} |

## Verification
The bench drives TOP around the full ring in both directions. A design that wraps the pointer wrongly would show the wrong ST(i) data once TOP passes 0 or 7. The bench pushes into a full stack and pops and checks an empty one. A faulting operation that still moved TOP or altered a tag would corrupt later readings.

The bench writes values at every tag boundary: a negative zero, an all-ones exponent, and a zero exponent with a non-zero significand. A classifier that looked at the sign, or that tested only the exponent, would mis-tag those words. Exchanges run over every index, including index 0 and an empty partner. A swap that copied only one side, or left the tags in place, would show up in ST(0) and ST(i). A long pseudo-random mix then compares every output against an arithmetic model after each operation.

// File: rtl/fp_stack_pkg.sv
package fp_stack_pkg;

    // Register tag encoding (R4)
    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    // Operation codes (R10); 6 and 7 fall through as idle
    localparam logic [2:0] OP_NOP   = 3'd0;
    localparam logic [2:0] OP_PUSH  = 3'd1;
    localparam logic [2:0] OP_POP   = 3'd2;
    localparam logic [2:0] OP_WRITE = 3'd3;
    localparam logic [2:0] OP_XCHG  = 3'd4;
    localparam logic [2:0] OP_CHECK = 3'd5;

    // Status field bit positions (R2)
    localparam int ST_OVF_BIT   = 0;
    localparam int ST_UNF_BIT   = 1;
    localparam int ST_FAULT_BIT = 2;
    localparam int ST_TOP_LSB   = 3;

    // Decoded per-cycle fault result
    typedef struct packed {
        logic ovf;
        logic unf;
    } fault_t;

endpackage

// File: rtl/fp_stack_classify.sv
module fp_stack_classify
    import fp_stack_pkg::*;
#(
    parameter int DATA_W = 80,
    parameter int EXP_W  = 15,
    localparam int MAG_W = DATA_W - 1,
    localparam int MAN_W = MAG_W - EXP_W
) (
    input  logic [MAG_W-1:0] mag_i,
    output tag_e             tag_o
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = mag_i[MAG_W-1 -: EXP_W];
    assign man_f = mag_i[MAN_W-1:0];

    always_comb begin
        if (&exp_f) begin
            tag_o = TAG_SPECIAL;
        end else if ((exp_f == '0) && (man_f == '0)) begin
            tag_o = TAG_ZERO;
        end else begin
            tag_o = TAG_VALID;
        end
    end

endmodule

// File: rtl/fp_stack_ctl.sv
module fp_stack_ctl
    import fp_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [2:0]         op_i,
    input  logic [PTR_W-1:0]   idx_i,
    input  logic [PTR_W-1:0]   top_i,
    input  logic [2*DEPTH-1:0] tags_i,
    output logic [PTR_W-1:0]   top_next_o,
    output logic [PTR_W-1:0]   st0_idx_o,
    output logic [PTR_W-1:0]   sti_idx_o,
    output logic               a_we_o,
    output logic [PTR_W-1:0]   a_idx_o,
    output logic               a_from_sti_o,
    output logic               b_we_o,
    output logic [PTR_W-1:0]   b_idx_o,
    output logic               free_we_o,
    output logic [PTR_W-1:0]   free_idx_o,
    output fault_t             fault_o
);

    logic [PTR_W-1:0] below;
    logic [PTR_W-1:0] above;
    tag_e             below_tag;
    tag_e             st0_tag;
    tag_e             sti_tag;

    assign st0_idx_o = top_i;
    assign sti_idx_o = top_i + idx_i;
    assign below     = top_i - PTR_W'(1);
    assign above     = top_i + PTR_W'(1);

    assign below_tag = tag_e'(tags_i[2*below +: 2]);
    assign st0_tag   = tag_e'(tags_i[2*top_i +: 2]);
    assign sti_tag   = tag_e'(tags_i[2*sti_idx_o +: 2]);

    always_comb begin
        top_next_o   = top_i;
        a_we_o       = 1'b0;
        a_idx_o      = sti_idx_o;
        a_from_sti_o = 1'b0;
        b_we_o       = 1'b0;
        b_idx_o      = sti_idx_o;
        free_we_o    = 1'b0;
        free_idx_o   = top_i;
        fault_o      = '0;
        case (op_i)
            OP_PUSH: begin
                if (below_tag != TAG_EMPTY) begin
                    fault_o.ovf = 1'b1;
                end else begin
                    a_we_o     = 1'b1;
                    a_idx_o    = below;
                    top_next_o = below;
                end
            end
            OP_POP: begin
                if (st0_tag == TAG_EMPTY) begin
                    fault_o.unf = 1'b1;
                end else begin
                    free_we_o  = 1'b1;
                    top_next_o = above;
                end
            end
            OP_WRITE: begin
                a_we_o = 1'b1;
            end
            OP_XCHG: begin
                a_we_o       = 1'b1;
                a_idx_o      = top_i;
                a_from_sti_o = 1'b1;
                b_we_o       = 1'b1;
            end
            OP_CHECK: begin
                fault_o.unf = (sti_tag == TAG_EMPTY);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fp_stack_bank.sv
module fp_stack_bank
    import fp_stack_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 80,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               a_we_i,
    input  logic [PTR_W-1:0]   a_idx_i,
    input  logic [DATA_W-1:0]  a_data_i,
    input  tag_e               a_tag_i,
    input  logic               b_we_i,
    input  logic [PTR_W-1:0]   b_idx_i,
    input  logic [DATA_W-1:0]  b_data_i,
    input  tag_e               b_tag_i,
    input  logic               free_we_i,
    input  logic [PTR_W-1:0]   free_idx_i,
    input  logic [PTR_W-1:0]   rd0_idx_i,
    input  logic [PTR_W-1:0]   rd1_idx_i,
    output logic [DATA_W-1:0]  rd0_data_o,
    output logic [DATA_W-1:0]  rd1_data_o,
    output logic [2*DEPTH-1:0] tag_word_o
);

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_row
        logic [DATA_W-1:0] word_q;
        tag_e              tag_q;
        logic              hit_a;
        logic              hit_b;
        logic              hit_free;

        assign hit_a    = a_we_i    && (a_idx_i    == PTR_W'(k));
        assign hit_b    = b_we_i    && (b_idx_i    == PTR_W'(k));
        assign hit_free = free_we_i && (free_idx_i == PTR_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
                tag_q  <= TAG_EMPTY;
            end else if (hit_a) begin
                word_q <= a_data_i;
                tag_q  <= a_tag_i;
            end else if (hit_b) begin
                word_q <= b_data_i;
                tag_q  <= b_tag_i;
            end else if (hit_free) begin
                tag_q  <= TAG_EMPTY;
            end
        end

        assign words[k]              = word_q;
        assign tag_word_o[2*k +: 2]  = tag_q;
    end

    assign rd0_data_o = words[rd0_idx_i];
    assign rd1_data_o = words[rd1_idx_i];

endmodule

// File: rtl/fp_stack_file.sv
module fp_stack_file
    import fp_stack_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 80,
    parameter int EXP_W  = 15,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int STAT_W = PTR_W + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         op_i,
    input  logic [PTR_W-1:0]   idx_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  st0_data_o,
    output logic [1:0]         st0_tag_o,
    output logic [DATA_W-1:0]  sti_data_o,
    output logic [1:0]         sti_tag_o,
    output logic [2*DEPTH-1:0] tag_word_o,
    output logic [STAT_W-1:0]  status_o
);

    logic [PTR_W-1:0]   top_q;
    fault_t             fault_q;
    fault_t             fault_d;
    logic [PTR_W-1:0]   top_next;
    logic [PTR_W-1:0]   st0_idx;
    logic [PTR_W-1:0]   sti_idx;
    logic               a_we;
    logic [PTR_W-1:0]   a_idx;
    logic               a_from_sti;
    logic               b_we;
    logic [PTR_W-1:0]   b_idx;
    logic               free_we;
    logic [PTR_W-1:0]   free_idx;
    logic [2*DEPTH-1:0] tags;
    tag_e               in_tag;
    tag_e               st0_tag;
    tag_e               sti_tag;
    logic [DATA_W-1:0]  a_data;
    tag_e               a_tag;

    fp_stack_ctl #(.DEPTH(DEPTH)) u_ctl (
        .op_i         (op_i),
        .idx_i        (idx_i),
        .top_i        (top_q),
        .tags_i       (tags),
        .top_next_o   (top_next),
        .st0_idx_o    (st0_idx),
        .sti_idx_o    (sti_idx),
        .a_we_o       (a_we),
        .a_idx_o      (a_idx),
        .a_from_sti_o (a_from_sti),
        .b_we_o       (b_we),
        .b_idx_o      (b_idx),
        .free_we_o    (free_we),
        .free_idx_o   (free_idx),
        .fault_o      (fault_d)
    );

    fp_stack_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls (
        .mag_i (wr_data_i[DATA_W-2:0]),
        .tag_o (in_tag)
    );

    assign st0_tag = tag_e'(tags[2*st0_idx +: 2]);
    assign sti_tag = tag_e'(tags[2*sti_idx +: 2]);

    assign a_data = a_from_sti ? sti_data_o : wr_data_i;
    assign a_tag  = a_from_sti ? sti_tag    : in_tag;

    fp_stack_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .a_we_i     (a_we),
        .a_idx_i    (a_idx),
        .a_data_i   (a_data),
        .a_tag_i    (a_tag),
        .b_we_i     (b_we),
        .b_idx_i    (b_idx),
        .b_data_i   (st0_data_o),
        .b_tag_i    (st0_tag),
        .free_we_i  (free_we),
        .free_idx_i (free_idx),
        .rd0_idx_i  (st0_idx),
        .rd1_idx_i  (sti_idx),
        .rd0_data_o (st0_data_o),
        .rd1_data_o (sti_data_o),
        .tag_word_o (tags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q   <= '0;
            fault_q <= '0;
        end else begin
            top_q   <= top_next;
            fault_q <= fault_d;
        end
    end

    assign st0_tag_o  = st0_tag;
    assign sti_tag_o  = sti_tag;
    assign tag_word_o = tags;
    assign status_o   = {top_q, fault_q.ovf | fault_q.unf, fault_q.unf, fault_q.ovf};

endmodule

// File: rtl/fp_stack_chk.sv
module fp_stack_chk
    import fp_stack_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 80,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int STAT_W = PTR_W + 3
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         op_i,
    input logic [DATA_W-1:0]  st0_data_i,
    input logic [1:0]         st0_tag_i,
    input logic [DATA_W-1:0]  sti_data_i,
    input logic [1:0]         sti_tag_i,
    input logic [2*DEPTH-1:0] tag_word_i,
    input logic [STAT_W-1:0]  status_i
);

    logic [PTR_W-1:0] top;
    logic [PTR_W-1:0] top_m1;
    logic [PTR_W-1:0] top_p1;
    logic [1:0]       below_tag;
    logic             ovf;
    logic             unf;

    assign top       = status_i[ST_TOP_LSB +: PTR_W];
    assign top_m1    = top - PTR_W'(1);
    assign top_p1    = top + PTR_W'(1);
    assign below_tag = tag_word_i[2*top_m1 +: 2];
    assign ovf       = status_i[ST_OVF_BIT];
    assign unf       = status_i[ST_UNF_BIT];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (top == '0) && (&tag_word_i) && !ovf && !unf && !status_i[ST_FAULT_BIT]);

    // R3
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PUSH) |=> ovf || (top == $past(top_m1)));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PUSH) |=> !ovf || ($stable(tag_word_i) && $stable(top)));

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP) |=> unf || ((top == $past(top_p1)) && (below_tag == 2'b11)));

    // R5
    pop_fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP) |=> !unf || ($stable(tag_word_i) && $stable(top)));

    // R7
    xchg_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_XCHG) |=> (st0_data_i == $past(sti_data_i)) &&
                              (st0_tag_i == $past(sti_tag_i)) && $stable(top));

    // R8
    check_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CHECK) |=> $stable(tag_word_i) && $stable(top) && !ovf);

    // R9
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));

    // R9
    ovf_source_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_PUSH) |=> !ovf);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NOP || op_i == 3'd6 || op_i == 3'd7) |=>
            $stable(tag_word_i) && $stable(top) && !ovf && !unf);

endmodule

bind fp_stack_file fp_stack_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .st0_data_i (st0_data_o),
    .st0_tag_i  (st0_tag_o),
    .sti_data_i (sti_data_o),
    .sti_tag_i  (sti_tag_o),
    .tag_word_i (tag_word_o),
    .status_i   (status_o)
);

// File: tb/test_fp_stack_file.sv
`timescale 1ns/1ps
module test_fp_stack_file;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic [2:0]  idx_i;
    logic [79:0] wr_data_i;
    logic [79:0] st0_data_o;
    logic [1:0]  st0_tag_o;
    logic [79:0] sti_data_o;
    logic [1:0]  sti_tag_o;
    logic [15:0] tag_word_o;
    logic [5:0]  status_o;

    always #2.5 clk = ~clk;

    fp_stack_file i_fp_stack_file (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op_i),
        .idx_i      (idx_i),
        .wr_data_i  (wr_data_i),
        .st0_data_o (st0_data_o),
        .st0_tag_o  (st0_tag_o),
        .sti_data_o (sti_data_o),
        .sti_tag_o  (sti_tag_o),
        .tag_word_o (tag_word_o),
        .status_o   (status_o)
    );

    // Arithmetic model of the stack
    logic [79:0] m_data [8];
    logic [1:0]  m_tag  [8];
    logic [2:0]  m_top;
    logic        m_ovf;
    logic        m_unf;
    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] lcg   = 32'h1234_5678;

    function automatic logic [1:0] cls(input logic [79:0] v);
        if (&v[78:64]) return 2'b10;
        if (v[78:64] == 15'd0 && v[63:0] == 64'd0) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [79:0] mkval(input int kind, input int seed);
        logic [79:0] v;
        case (kind % 4)
            0: v = {seed[0], 15'h3FF0 + 15'(seed & 8'hFF), 64'h8000_0000_0000_0000 | 64'(seed)};
            1: v = {seed[1], 79'd0};
            2: v = {seed[0], 15'h7FFF, 64'(seed) * 64'h9E37};
            default: v = {1'b0, 15'd0, 64'(seed) + 64'd1};
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_data[k] = '0;
            m_tag[k]  = 2'b11;
        end
        m_top = '0;
        m_ovf = 1'b0;
        m_unf = 1'b0;
    endtask

    task automatic model_step(input logic [2:0] op, input logic [2:0] idx,
                              input logic [79:0] d);
        logic [2:0]  nt;
        logic [2:0]  p;
        logic [79:0] td;
        logic [1:0]  tt;
        nt = m_top - 3'd1;
        p  = m_top + idx;
        m_ovf = 1'b0;
        m_unf = 1'b0;
        case (op)
            3'd1: if (m_tag[nt] != 2'b11) m_ovf = 1'b1;
                  else begin m_data[nt] = d; m_tag[nt] = cls(d); m_top = nt; end
            3'd2: if (m_tag[m_top] == 2'b11) m_unf = 1'b1;
                  else begin m_tag[m_top] = 2'b11; m_top = m_top + 3'd1; end
            3'd3: begin m_data[p] = d; m_tag[p] = cls(d); end
            3'd4: begin
                td = m_data[m_top]; tt = m_tag[m_top];
                m_data[m_top] = m_data[p]; m_tag[m_top] = m_tag[p];
                m_data[p] = td; m_tag[p] = tt;
            end
            3'd5: m_unf = (m_tag[p] == 2'b11);
            default: ;
        endcase
    endtask

    task automatic check_all(input string req);
        logic [15:0] tw;
        logic [2:0]  p;
        for (int k = 0; k < 8; k++) tw[2*k +: 2] = m_tag[k];
        p = m_top + idx_i;
        chk(req, "status", 80'(status_o), 80'({m_top, m_ovf | m_unf, m_unf, m_ovf}));
        chk(req, "tag_word", 80'(tag_word_o), 80'(tw));
        chk(req, "st0_tag", 80'(st0_tag_o), 80'(m_tag[m_top]));
        if (m_tag[m_top] != 2'b11) chk(req, "st0_data", st0_data_o, m_data[m_top]);
        chk(req, "sti_tag", 80'(sti_tag_o), 80'(m_tag[p]));
        if (m_tag[p] != 2'b11) chk(req, "sti_data", sti_data_o, m_data[p]);
    endtask

    // Walk idx over every stack position with the op idle
    task automatic probe_all(input string req);
        for (int i = 0; i < 8; i++) begin
            idx_i = 3'(i);
            #1;
            chk(req, "sti_tag probe", 80'(sti_tag_o), 80'(m_tag[m_top + 3'(i)]));
            if (m_tag[m_top + 3'(i)] != 2'b11)
                chk(req, "sti_data probe", sti_data_o, m_data[m_top + 3'(i)]);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] d);
        @(negedge clk);
        op_i = op; idx_i = idx; wr_data_i = d;
        @(posedge clk);
        model_step(op, idx, d);
        @(negedge clk);
        op_i = 3'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        rst = 1'b1; op_i = 3'd0; idx_i = 3'd0; wr_data_i = '0;
        model_reset();
        do_reset();
        check_all("R1");
        probe_all("R1");

        // Unused codes and idle
        run(3'd6, 3'd2, mkval(0, 5)); check_all("R10");
        run(3'd7, 3'd0, mkval(2, 6)); check_all("R10");
        run(3'd0, 3'd1, mkval(0, 7)); check_all("R10");

        // Faults on empty stack
        run(3'd5, 3'd3, '0); check_all("R8");
        run(3'd0, 3'd0, '0); check_all("R9");
        run(3'd2, 3'd0, '0); check_all("R5");

        // Fill the stack with every tag class, top wraps from 0 to 7
        for (int n = 0; n < 8; n++) begin
            run(3'd1, 3'(n), mkval(n, n * 37 + 1));
            check_all("R3");
            check_all("R4");
        end
        probe_all("R2");
        run(3'd1, 3'd0, mkval(0, 99)); check_all("R3");
        run(3'd3, 3'd0, '0);            check_all("R9");

        // Overwrite every position
        for (int i = 0; i < 8; i++) begin
            run(3'd3, 3'(i), mkval(i + 1, i * 11 + 3));
            check_all("R6");
        end
        run(3'd3, 3'd4, {1'b1, 79'd0});                  check_all("R4");
        run(3'd3, 3'd5, {1'b0, 15'd0, 64'd1});           check_all("R4");
        run(3'd3, 3'd6, {1'b1, 15'h7FFF, 64'd0});        check_all("R4");
        probe_all("R6");

        // Exchange with every index
        for (int i = 0; i < 8; i++) begin
            run(3'd4, 3'(i), '0);
            check_all("R7");
        end
        run(3'd5, 3'd7, '0); check_all("R8");

        // Drain, then underflow
        for (int n = 0; n < 8; n++) begin
            run(3'd2, 3'd0, '0);
            check_all("R5");
        end
        run(3'd2, 3'd0, '0); check_all("R5");
        probe_all("R5");

        // Exchange with an empty partner, write into an empty slot
        run(3'd1, 3'd0, mkval(0, 200)); check_all("R3");
        run(3'd1, 3'd0, mkval(2, 201)); check_all("R3");
        run(3'd4, 3'd5, '0);            check_all("R7");
        run(3'd5, 3'd0, '0);            check_all("R8");
        run(3'd3, 3'd3, mkval(1, 202)); check_all("R6");
        probe_all("R7");

        // Pseudo-random mix across all tops
        for (int n = 0; n < 400; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run(3'(lcg[30:28] % 3'd6), lcg[22:20], mkval(int'(lcg[15:13]), int'(lcg[11:0])));
            check_all("R2");
        end

        // Reset from a busy state
        do_reset();
        check_all("R1");
        probe_all("R1");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(100000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule